// File: doc/BRIEF.md
# Slow-Clock Programmable Waveform Output

This block drives two output pins from a 32.768 kHz slow clock. Each pin has its own 3-bit source selector and can show one of eight things: a constant low level, one of four fixed square waves, the alarm flag passed straight through, a level that flips on each new alarm, or a pulse train whose period and high time come from two small code inputs. Both pins share those two pulse codes.

A free-running 15-bit divider paces everything. All square waves and the pulse train are taken from this single divider, so their edges always line up. Changing a selector does not reset the divider. The new source appears on the pin at the next slow-clock edge. The alarm flag is taken to belong to the same slow clock domain.

Top module: `slowclk_wave_out`

## Requirements
- R1: While rst_n is low both outputs are 0. The edge count n starts at 0 and goes up by one on each rising clock edge after release, wrapping modulo 32768. Each output value below is the value that holds after edge n.
- R2: Selector code 0 holds the output at 0.
- R3: Selector codes 1, 2, 3 and 4 give 50%-duty square waves at 1 Hz, 32 Hz, 64 Hz and 512 Hz. These equal bit 14, bit 9, bit 8 and bit 5 of n.
- R4: Selector code 5 shows a toggle level that is shared by both outputs. It is 0 after reset and inverts at every edge where alarm_i is 1 and was 0 at the previous edge.
- R5: Selector code 6 copies alarm_i as sampled at the latest edge.
- R6: Selector code 7 gives a pulse train. Period codes 0, 1, 2 and 3 set periods of 32768, 16384, 8192 and 4096 cycles. The pulse position is n modulo the period, and the pulse is high from position 0.
- R7: High-time codes 0 to 6 keep the pulse high while the position is below 1024, 512, 128, 32, 16, 4 or 1 cycles.
- R8: High-time code 7 makes a half-cycle pulse. The output is high only during the low phase of the clock, and only in the cycle where the position is 0.
- R9: The two selectors act independently. The period code and the high-time code are shared by both outputs.
- R10: A change of a selector, a period code or a high-time code takes effect at the next rising edge and does not restart the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32.768 kHz slow clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_i | input | 1 | Alarm flag, in the slow clock domain |
| src_sel0 | input | 3 | Source code for output 0 |
| src_sel1 | input | 3 | Source code for output 1 |
| high_code | input | 3 | Pulse high-time code (shared) |
| period_code | input | 2 | Pulse period code (shared) |
| wave0_o | output | 1 | Output pin 0 |
| wave1_o | output | 1 | Output pin 1 |

## Verification
The assertions assume that alarm_i and every code input change only between rising edges of the slow clock, never at an edge. They also assume that nothing but reset ever restarts the divider. The bench respects both assumptions. It drives all inputs shortly after the falling edge, holds rst_n low only at the start, and lets the divider run through a full 32768-cycle wrap while the selectors and codes are changed at random.

// File: rtl/wave_out_pkg.sv
package wave_out_pkg;

    localparam int SEL_W = 3;
    localparam int HT_W  = 3;
    localparam int PER_W = 2;
    localparam int HL_W  = 11;

    typedef enum logic [SEL_W-1:0] {
        SRC_LOW      = 3'd0,
        SRC_SQ_1HZ   = 3'd1,
        SRC_SQ_32HZ  = 3'd2,
        SRC_SQ_64HZ  = 3'd3,
        SRC_SQ_512HZ = 3'd4,
        SRC_ALM_TOG  = 3'd5,
        SRC_ALM_COPY = 3'd6,
        SRC_PULSE    = 3'd7
    } src_sel_e;

    // Next-cycle values of every selectable source, shared by all output muxes.
    typedef struct packed {
        logic sq_1hz;
        logic sq_32hz;
        logic sq_64hz;
        logic sq_512hz;
        logic alm_tog;
        logic alm_copy;
        logic pulse;
        logic half_mode;
    } src_bus_t;

    localparam logic [HT_W-1:0] HT_HALF = 3'd7;

    // High time in slow-clock cycles; the half-cycle code is handled apart.
    function automatic logic [HL_W-1:0] high_len(input logic [HT_W-1:0] code);
        logic [HL_W-1:0] len;
        case (code)
            3'd0:    len = 11'd1024;
            3'd1:    len = 11'd512;
            3'd2:    len = 11'd128;
            3'd3:    len = 11'd32;
            3'd4:    len = 11'd16;
            3'd5:    len = 11'd4;
            3'd6:    len = 11'd1;
            default: len = 11'd0;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/wave_divider.sv
module wave_divider
    import wave_out_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int TAP_1HZ  = 14,
    parameter int TAP_32HZ = 9,
    parameter int TAP_64HZ = 8,
    parameter int TAP_512  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HT_W-1:0]  high_code,
    input  logic [PER_W-1:0] period_code,
    output logic             sq_1hz_nxt,
    output logic             sq_32hz_nxt,
    output logic             sq_64hz_nxt,
    output logic             sq_512_nxt,
    output logic             pulse_nxt,
    output logic             half_mode
);

    localparam logic [DIV_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] pos_mask;
    logic [DIV_W-1:0] pos_d;
    logic [DIV_W-1:0] hi_len_ext;

    always_comb begin
        st_d        = st_q;
        st_d.cnt    = st_q.cnt + 1'b1;
        pos_mask    = CNT_MAX >> period_code;
        pos_d       = st_d.cnt & pos_mask;
        hi_len_ext  = DIV_W'(high_len(high_code));
        half_mode   = (high_code == HT_HALF);
        sq_1hz_nxt  = st_d.cnt[TAP_1HZ];
        sq_32hz_nxt = st_d.cnt[TAP_32HZ];
        sq_64hz_nxt = st_d.cnt[TAP_64HZ];
        sq_512_nxt  = st_d.cnt[TAP_512];
        if (half_mode) begin
            pulse_nxt = (pos_d == '0);
        end else begin
            pulse_nxt = (pos_d < hi_len_ext);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the divider wraps to zero after its top value
    p_div_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.cnt) == CNT_MAX) |-> (st_q.cnt == '0));

    // R10: the divider only ever steps by one while out of reset
    p_div_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/wave_alarm_track.sv
module wave_alarm_track (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_i,
    output logic tog_nxt,
    output logic copy_nxt
);

    typedef struct packed {
        logic alm;
        logic tog;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d     = st_q;
        rise     = alarm_i & ~st_q.alm;
        st_d.alm = alarm_i;
        st_d.tog = st_q.tog ^ rise;
        tog_nxt  = st_d.tog;
        copy_nxt = alarm_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a new alarm inverts the toggle level
    p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_i && !st_q.alm) |=> (st_q.tog != $past(st_q.tog)));

    // R4: without a new alarm the toggle level holds
    p_tog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(alarm_i && !st_q.alm) |=> $stable(st_q.tog));

endmodule

// File: rtl/wave_src_mux.sv
module wave_src_mux
    import wave_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  src_bus_t         src_i,
    output logic             wave_o
);

    typedef struct packed {
        logic lvl;
        logic gate;
    } mux_state_t;

    mux_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.gate = 1'b0;
        case (src_sel_e'(sel_i))
            SRC_LOW:      st_d.lvl = 1'b0;
            SRC_SQ_1HZ:   st_d.lvl = src_i.sq_1hz;
            SRC_SQ_32HZ:  st_d.lvl = src_i.sq_32hz;
            SRC_SQ_64HZ:  st_d.lvl = src_i.sq_64hz;
            SRC_SQ_512HZ: st_d.lvl = src_i.sq_512hz;
            SRC_ALM_TOG:  st_d.lvl = src_i.alm_tog;
            SRC_ALM_COPY: st_d.lvl = src_i.alm_copy;
            SRC_PULSE: begin
                st_d.lvl  = src_i.pulse;
                st_d.gate = src_i.half_mode;
            end
            default:      st_d.lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-cycle pulse: only let the level through in the clock low phase.
    assign wave_o = st_q.lvl & ~(st_q.gate & clk);

    // R2: code 0 gives a low level after the edge
    p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SRC_LOW) |=> !st_q.lvl);

    // R5: copy mode shows the alarm sampled at the previous edge
    p_copy_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SRC_ALM_COPY) |=> (st_q.lvl == $past(src_i.alm_copy)));

    // R8: the gate is only armed in pulse mode
    p_gate_pulse_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != SRC_PULSE) |=> !st_q.gate);

endmodule

// File: rtl/slowclk_wave_out.sv
module slowclk_wave_out
    import wave_out_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int TAP_1HZ  = 14,
    parameter int TAP_32HZ = 9,
    parameter int TAP_64HZ = 8,
    parameter int TAP_512  = 5
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             alarm_i,
    input  logic [2:0]       src_sel0,
    input  logic [2:0]       src_sel1,
    input  logic [2:0]       high_code,
    input  logic [1:0]       period_code,
    output logic             wave0_o,
    output logic             wave1_o
);

    localparam int NUM_OUT = 2;

    src_bus_t         src_bus;
    logic [SEL_W-1:0] sel_arr  [NUM_OUT];
    logic             wave_arr [NUM_OUT];

    assign sel_arr[0] = src_sel0;
    assign sel_arr[1] = src_sel1;

    wave_divider #(
        .DIV_W    (DIV_W),
        .TAP_1HZ  (TAP_1HZ),
        .TAP_32HZ (TAP_32HZ),
        .TAP_64HZ (TAP_64HZ),
        .TAP_512  (TAP_512)
    ) u_div (
        .clk         (clk_slow),
        .rst_n       (rst_n),
        .high_code   (high_code),
        .period_code (period_code),
        .sq_1hz_nxt  (src_bus.sq_1hz),
        .sq_32hz_nxt (src_bus.sq_32hz),
        .sq_64hz_nxt (src_bus.sq_64hz),
        .sq_512_nxt  (src_bus.sq_512hz),
        .pulse_nxt   (src_bus.pulse),
        .half_mode   (src_bus.half_mode)
    );

    wave_alarm_track u_alm (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .alarm_i  (alarm_i),
        .tog_nxt  (src_bus.alm_tog),
        .copy_nxt (src_bus.alm_copy)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        wave_src_mux u_mux (
            .clk    (clk_slow),
            .rst_n  (rst_n),
            .sel_i  (sel_arr[g]),
            .src_i  (src_bus),
            .wave_o (wave_arr[g])
        );
    end

    assign wave0_o = wave_arr[0];
    assign wave1_o = wave_arr[1];

    // R1: both pins stay low through reset
    p_reset_low_r1: assert property (@(posedge clk_slow)
        !rst_n |=> (!wave0_o && !wave1_o) || rst_n);

endmodule

// File: tb/sim_slowclk_wave_out.sv
module sim_slowclk_wave_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm = 1'b0;
    logic [2:0] sel0 = 3'd0;
    logic [2:0] sel1 = 3'd0;
    logic [2:0] hc = 3'd0;
    logic [1:0] pc = 2'd0;
    logic       w0, w1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state, updated at each rising edge from requirements.
    int   mcnt = 0;
    logic mtog = 1'b0;
    logic mprev = 1'b0;
    logic malm = 1'b0;
    int   ms0 = 0, ms1 = 0, mhc = 0, mpc = 0;

    always #5 clk = ~clk;

    slowclk_wave_out u0 (
        .clk_slow    (clk),
        .rst_n       (rst_n),
        .alarm_i     (alarm),
        .src_sel0    (sel0),
        .src_sel1    (sel1),
        .high_code   (hc),
        .period_code (pc),
        .wave0_o     (w0),
        .wave1_o     (w1)
    );

    function automatic int hlen(int code);
        case (code)
            0: return 1024;
            1: return 512;
            2: return 128;
            3: return 32;
            4: return 16;
            5: return 4;
            6: return 1;
            default: return 0;
        endcase
    endfunction

    // R2..R8 expected level for one output
    function automatic logic exp_out(int s, int n, logic alm, logic tog,
                                     int h, int p, logic ph_high);
        int per = 32768 >> p;
        int pos = n % per;
        case (s)
            0: return 1'b0;
            1: return n[14];
            2: return n[9];
            3: return n[8];
            4: return n[5];
            5: return tog;
            6: return alm;
            default: begin
                if (h == 7) return (pos == 0) && !ph_high;
                return pos < hlen(h);
            end
        endcase
    endfunction

    function automatic string req_of(int s, int h);
        case (s)
            0: return "R2";
            1, 2, 3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            default: return (h == 7) ? "R8" : "R6/R7";
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s n=%0d actual=%b expected=%b", req, what, mcnt, act, exp);
        end
    endtask

    task automatic check_both(logic ph_high);
        check(req_of(ms0, mhc), w0, exp_out(ms0, mcnt, malm, mtog, mhc, mpc, ph_high), "wave0");
        check(req_of(ms1, mhc), w1, exp_out(ms1, mcnt, malm, mtog, mhc, mpc, ph_high), "wave1");
    endtask

    // One clock: model update at the edge, checks in both phases.
    task automatic step();
        @(posedge clk);
        mcnt  = (mcnt + 1) % 32768;
        mtog  = mtog ^ (alarm & ~mprev);
        mprev = alarm;
        malm  = alarm;
        ms0 = int'(sel0); ms1 = int'(sel1); mhc = int'(hc); mpc = int'(pc);
        #2 check_both(1'b1);
        @(negedge clk);
        #2 check_both(1'b0);
    endtask

    task automatic run(int cycles, bit rnd_alarm);
        for (int i = 0; i < cycles; i++) begin
            step();
            if (rnd_alarm && ($urandom % 8 == 0)) alarm = ~alarm;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: outputs low during reset, even with pulse and half-cycle selected
        sel0 = 3'd7; sel1 = 3'd6; hc = 3'd7; alarm = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #2;
            check("R1", w0, 1'b0, "wave0 in reset");
            check("R1", w1, 1'b0, "wave1 in reset");
        end
        @(negedge clk); #2;
        alarm = 1'b0; sel0 = 3'd7; sel1 = 3'd1; hc = 3'd0; pc = 2'd0;
        rst_n = 1'b1;
        // R6 R7 R3: full divider wrap with 1 s period and 1 Hz square wave
        run(33000, 1'b0);
        // R8 R4 R9: half-cycle pulse on one pin, alarm toggle on the other
        sel0 = 3'd7; sel1 = 3'd5; hc = 3'd7; pc = 2'd3;
        run(9000, 1'b1);
        // R5 R3: 512 Hz and alarm copy
        sel0 = 3'd4; sel1 = 3'd6; hc = 3'd6;
        run(2000, 1'b1);
        // R10 R9: random selectors and codes changing without divider restart
        for (int seg = 0; seg < 24; seg++) begin
            sel0 = 3'($urandom); sel1 = 3'($urandom);
            hc = 3'($urandom); pc = 2'($urandom);
            run(200 + ($urandom % 2500), 1'b1);
        end
        // R10: selector changes every cycle
        for (int i = 0; i < 3000; i++) begin
            sel0 = 3'($urandom); sel1 = 3'($urandom);
            step();
            if ($urandom % 4 == 0) alarm = ~alarm;
        end
        // R2: constant low on both pins with a busy alarm
        sel0 = 3'd0; sel1 = 3'd0;
        run(500, 1'b1);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule